// File: doc/BRIEF.md
# In-Order Completion Controller for Dual Execution Units

This block sits between an instruction queue and the register file write port. Each cycle it looks at the queue head and decides whether to dispatch it. An integer operation goes to a unit that takes one cycle. A floating-point operation goes to a unit that holds its operate stage for three cycles. Both units may be busy in the same cycle. Every dispatched instruction gets a sequence number and an entry in a completion queue. Results leave that queue only from its oldest entry, so the register file sees writes strictly in program order. A short operation that finishes early therefore waits behind an older long one.

An instruction can carry an exception flag from decode. The exception is raised only when that instruction becomes the oldest completed entry. By then every older result has been written and no younger result has been. In that cycle the block reports the faulting sequence number and discards every younger entry, including any in flight in the units. It also asks the instruction queue to drop its head. The arithmetic is a placeholder: the integer unit returns operand + 1, and the floating-point unit returns operand × 3, truncated to the data width.

Top module: `inorder_commit_ctrl`

## Requirements
- R1: Out of reset, `wb_valid_o`, `exc_valid_o` and `iq_clear_o` are 0. With an empty queue, a valid head is accepted at once (`iq_pop_o` = 1).
- R2: An integer instruction accepted in cycle d (`iq_is_fp_i` = 0) has its result ready from cycle d+2. The result is operand + 1, modulo 2^DATA_W.
- R3: A floating-point instruction accepted in cycle d (`iq_is_fp_i` = 1) has its result ready from cycle d+4. The result is operand × 3, modulo 2^DATA_W.
- R4: Completions leave in dispatch order. The oldest entry leaves in the first cycle in which its result is ready, so a younger integer result waits for an older floating-point one.
- R5: At most one completion happens per cycle. `wb_valid_o` and `exc_valid_o` are never 1 together.
- R6: A floating-point instruction is not accepted in the two cycles that follow the acceptance of another floating-point instruction. Integer instructions are not held back by the floating-point unit.
- R7: While DEPTH entries are outstanding, `iq_pop_o` stays 0.
- R8: When an entry whose exception flag is set becomes the oldest ready entry, three things happen for exactly one cycle: `exc_valid_o` = 1 with `exc_seq_o` set to its sequence number, `iq_clear_o` = 1, and `iq_pop_o` = 0. Every older entry has already been written back, and no younger entry is ever written back.
- R9: In the cycle after an exception the queue and both units are empty, and a new head is accepted at once.
- R10: Sequence numbers start at 0 after reset and grow by one per accepted instruction, modulo 2^SEQ_W. Flushed entries still consume their numbers. `wb_seq_o` carries the number of the entry being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iq_valid_i | input | 1 | Instruction queue head is valid |
| iq_is_fp_i | input | 1 | 1 = floating-point unit, 0 = integer unit |
| iq_dest_i | input | DEST_W | Destination register of the head |
| iq_opnd_i | input | DATA_W | Source operand of the head |
| iq_exc_i | input | 1 | Head carries an exception |
| iq_pop_o | output | 1 | Head accepted this cycle |
| iq_clear_o | output | 1 | Drop the instruction queue head (exception) |
| wb_valid_o | output | 1 | Register file write this cycle |
| wb_dest_o | output | DEST_W | Write destination |
| wb_data_o | output | DATA_W | Write data |
| wb_seq_o | output | SEQ_W | Sequence number of the written entry |
| exc_valid_o | output | 1 | Precise exception raised this cycle |
| exc_seq_o | output | SEQ_W | Sequence number of the faulting instruction |

## Verification
The hardest situation to reach is a full completion queue. Completions drain one per cycle as soon as the oldest result is ready, so the queue fills only when a floating-point instruction at the head blocks a run of fast integer instructions behind it. The bench builds the block with a queue of four entries and sends a floating-point instruction followed by five integer ones back to back, which forces the stall. It also sweeps every integer/floating-point mix of five instructions, with the exception placed at each position in turn. This covers flushes that catch younger work inside each unit.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int FP_LAT = 3;

  typedef enum logic {
    UNIT_INT = 1'b0,
    UNIT_FP  = 1'b1
  } unit_e;
endpackage

// File: rtl/cq_int_unit.sv
module cq_int_unit #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic              done_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] result_o
);
  logic              v_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] opnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      idx_q  <= '0;
      opnd_q <= '0;
    end else begin
      v_q <= issue_i && !flush_i;
      if (issue_i) begin
        idx_q  <= idx_i;
        opnd_q <= opnd_i;
      end
    end
  end

  assign done_o   = v_q;
  assign idx_o    = idx_q;
  assign result_o = opnd_q + DATA_W'(1);
endmodule

// File: rtl/cq_fp_unit.sv
module cq_fp_unit #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3,
  parameter int LAT    = cq_pkg::FP_LAT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              issue_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] opnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      opnd_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (issue_i) begin
      cnt_q  <= CNT_W'(LAT);
      idx_q  <= idx_i;
      opnd_q <= opnd_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // a new op may enter in the last cycle of the current one
  assign busy_o   = cnt_q > CNT_W'(1);
  assign done_o   = cnt_q == CNT_W'(1);
  assign idx_o    = idx_q;
  assign result_o = opnd_q + (opnd_q << 1);
endmodule

// File: rtl/cq_queue.sv
module cq_queue #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic [DEST_W-1:0] alloc_dest_i,
  input  logic              alloc_exc_i,
  output logic [IDX_W-1:0]  alloc_idx_o,
  output logic              full_o,
  input  logic              int_done_i,
  input  logic [IDX_W-1:0]  int_idx_i,
  input  logic [DATA_W-1:0] int_data_i,
  input  logic              fp_done_i,
  input  logic [IDX_W-1:0]  fp_idx_i,
  input  logic [DATA_W-1:0] fp_data_i,
  input  logic              pop_i,
  output logic              head_ready_o,
  output logic              head_exc_o,
  output logic [SEQ_W-1:0]  head_seq_o,
  output logic [DEST_W-1:0] head_dest_o,
  output logic [DATA_W-1:0] head_data_o
);
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [SEQ_W-1:0] seq_q;

  logic              done_a [DEPTH];
  logic              exc_a  [DEPTH];
  logic [SEQ_W-1:0]  seq_a  [DEPTH];
  logic [DEST_W-1:0] dest_a [DEPTH];
  logic [DATA_W-1:0] data_a [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              done_q, exc_q;
    logic [SEQ_W-1:0]  sq_q;
    logic [DEST_W-1:0] dest_q;
    logic [DATA_W-1:0] data_q;
    logic alloc_here, int_here, fp_here;

    assign alloc_here = alloc_i && (tail_q == IDX_W'(i));
    assign int_here   = int_done_i && (int_idx_i == IDX_W'(i));
    assign fp_here    = fp_done_i && (fp_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        done_q <= 1'b0;
        exc_q  <= 1'b0;
        sq_q   <= '0;
        dest_q <= '0;
        data_q <= '0;
      end else if (flush_i) begin
        done_q <= 1'b0;
      end else begin
        if (alloc_here) begin
          done_q <= 1'b0;
          exc_q  <= alloc_exc_i;
          sq_q   <= seq_q;
          dest_q <= alloc_dest_i;
        end
        if (int_here) begin
          done_q <= 1'b1;
          data_q <= int_data_i;
        end
        if (fp_here) begin
          done_q <= 1'b1;
          data_q <= fp_data_i;
        end
      end
    end

    assign done_a[i] = done_q;
    assign exc_a[i]  = exc_q;
    assign seq_a[i]  = sq_q;
    assign dest_a[i] = dest_q;
    assign data_a[i] = data_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      seq_q   <= '0;
    end else if (flush_i) begin
      // sequence numbers keep running across a flush
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop_i)   head_q <= head_q + IDX_W'(1);
      if (alloc_i) begin
        tail_q <= tail_q + IDX_W'(1);
        seq_q  <= seq_q + SEQ_W'(1);
      end
      count_q <= count_q + CNT_W'(alloc_i) - CNT_W'(pop_i);
    end
  end

  assign alloc_idx_o  = tail_q;
  assign full_o       = count_q == CNT_W'(DEPTH);
  assign head_ready_o = (count_q != '0) && done_a[head_q];
  assign head_exc_o   = exc_a[head_q];
  assign head_seq_o   = seq_a[head_q];
  assign head_dest_o  = dest_a[head_q];
  assign head_data_o  = data_a[head_q];
endmodule

// File: rtl/inorder_commit_ctrl.sv
module inorder_commit_ctrl #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5,
  parameter int SEQ_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iq_valid_i,
  input  logic              iq_is_fp_i,
  input  logic [DEST_W-1:0] iq_dest_i,
  input  logic [DATA_W-1:0] iq_opnd_i,
  input  logic              iq_exc_i,
  output logic              iq_pop_o,
  output logic              iq_clear_o,
  output logic              wb_valid_o,
  output logic [DEST_W-1:0] wb_dest_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic [SEQ_W-1:0]  wb_seq_o,
  output logic              exc_valid_o,
  output logic [SEQ_W-1:0]  exc_seq_o
);
  import cq_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  unit_e             unit_sel;
  logic              full, fp_busy, dispatch, commit, flush;
  logic [IDX_W-1:0]  alloc_idx;
  logic              int_done, fp_done;
  logic [IDX_W-1:0]  int_idx, fp_idx;
  logic [DATA_W-1:0] int_res, fp_res;
  logic              head_ready, head_exc;
  logic [SEQ_W-1:0]  head_seq;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_data;

  assign unit_sel = unit_e'(iq_is_fp_i);
  assign commit   = head_ready;
  assign flush    = commit && head_exc;
  assign dispatch = iq_valid_i && !full && !flush &&
                    !((unit_sel == UNIT_FP) && fp_busy);

  cq_queue #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .DEST_W(DEST_W),
    .SEQ_W (SEQ_W)
  ) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .alloc_i     (dispatch),
    .alloc_dest_i(iq_dest_i),
    .alloc_exc_i (iq_exc_i),
    .alloc_idx_o (alloc_idx),
    .full_o      (full),
    .int_done_i  (int_done),
    .int_idx_i   (int_idx),
    .int_data_i  (int_res),
    .fp_done_i   (fp_done),
    .fp_idx_i    (fp_idx),
    .fp_data_i   (fp_res),
    .pop_i       (commit),
    .head_ready_o(head_ready),
    .head_exc_o  (head_exc),
    .head_seq_o  (head_seq),
    .head_dest_o (head_dest),
    .head_data_o (head_data)
  );

  cq_int_unit #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W)
  ) u_int (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .issue_i (dispatch && (unit_sel == UNIT_INT)),
    .idx_i   (alloc_idx),
    .opnd_i  (iq_opnd_i),
    .done_o  (int_done),
    .idx_o   (int_idx),
    .result_o(int_res)
  );

  cq_fp_unit #(
    .DATA_W(DATA_W),
    .IDX_W (IDX_W),
    .LAT   (FP_LAT)
  ) u_fp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .issue_i (dispatch && (unit_sel == UNIT_FP)),
    .idx_i   (alloc_idx),
    .opnd_i  (iq_opnd_i),
    .busy_o  (fp_busy),
    .done_o  (fp_done),
    .idx_o   (fp_idx),
    .result_o(fp_res)
  );

  assign iq_pop_o    = dispatch;
  assign iq_clear_o  = flush;
  assign wb_valid_o  = commit && !head_exc;
  assign wb_dest_o   = head_dest;
  assign wb_data_o   = head_data;
  assign wb_seq_o    = head_seq;
  assign exc_valid_o = flush;
  assign exc_seq_o   = head_seq;
endmodule

// File: rtl/cq_commit_chk.sv
module cq_commit_chk #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iq_is_fp_i,
  input logic             iq_pop_o,
  input logic             iq_clear_o,
  input logic             wb_valid_o,
  input logic [SEQ_W-1:0] wb_seq_o,
  input logic             exc_valid_o
);
  int             occ_q;
  logic           have_last_q;
  logic [SEQ_W-1:0] last_seq_q;
  logic           fp_pop;

  assign fp_pop = iq_pop_o && iq_is_fp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q       <= 0;
      have_last_q <= 1'b0;
      last_seq_q  <= '0;
    end else if (exc_valid_o) begin
      occ_q       <= 0;
      have_last_q <= 1'b0;
    end else begin
      occ_q <= occ_q + int'(iq_pop_o) - int'(wb_valid_o);
      if (wb_valid_o) begin
        have_last_q <= 1'b1;
        last_seq_q  <= wb_seq_o;
      end
    end
  end

  // R5
  wb_exc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_valid_o && exc_valid_o));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= DEPTH);

  // R7
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == DEPTH) |-> !iq_pop_o);

  // R4
  commit_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && have_last_q) |-> (wb_seq_o == SEQ_W'(last_seq_q + 1'b1)));

  // R8
  exc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |=> (!exc_valid_o && !wb_valid_o));

  // R8
  exc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> (iq_clear_o && !iq_pop_o));

  // R6
  fp_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_pop && !$past(exc_valid_o)) |-> (!$past(fp_pop) && !$past(fp_pop, 2)));

  // R2
  int_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iq_pop_o && !iq_is_fp_i && occ_q == 0) |=> ##1 (wb_valid_o || exc_valid_o));

  // R3
  fp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_pop && occ_q == 0) |=> ##3 (wb_valid_o || exc_valid_o));
endmodule

bind inorder_commit_ctrl cq_commit_chk #(
  .DEPTH(DEPTH),
  .SEQ_W(SEQ_W)
) u_commit_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .iq_is_fp_i (iq_is_fp_i),
  .iq_pop_o   (iq_pop_o),
  .iq_clear_o (iq_clear_o),
  .wb_valid_o (wb_valid_o),
  .wb_seq_o   (wb_seq_o),
  .exc_valid_o(exc_valid_o)
);

// File: tb/tb_inorder_commit_ctrl.sv
module tb_inorder_commit_ctrl;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 16;
  localparam int DEST_W = 5;
  localparam int SEQ_W  = 4;
  localparam int SEQ_M  = 1 << SEQ_W;
  localparam int DMASK  = (1 << DATA_W) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              iq_valid_i = 1'b0;
  logic              iq_is_fp_i = 1'b0;
  logic [DEST_W-1:0] iq_dest_i = '0;
  logic [DATA_W-1:0] iq_opnd_i = '0;
  logic              iq_exc_i = 1'b0;
  logic              iq_pop_o, iq_clear_o, wb_valid_o, exc_valid_o;
  logic [DEST_W-1:0] wb_dest_o;
  logic [DATA_W-1:0] wb_data_o;
  logic [SEQ_W-1:0]  wb_seq_o, exc_seq_o;

  inorder_commit_ctrl #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .SEQ_W(SEQ_W)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .iq_valid_i(iq_valid_i), .iq_is_fp_i(iq_is_fp_i), .iq_dest_i(iq_dest_i),
    .iq_opnd_i(iq_opnd_i), .iq_exc_i(iq_exc_i),
    .iq_pop_o(iq_pop_o), .iq_clear_o(iq_clear_o),
    .wb_valid_o(wb_valid_o), .wb_dest_o(wb_dest_o), .wb_data_o(wb_data_o),
    .wb_seq_o(wb_seq_o), .exc_valid_o(exc_valid_o), .exc_seq_o(exc_seq_o)
  );

  always #4 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int m_seq [64], m_dest [64], m_data [64], m_rdy [64];
  bit m_exc [64];
  int mh = 0, mt = 0, mc = 0, nseq = 0, last_fp = -100;
  int wb_seen = 0, full_stalls = 0;
  bit after_exc = 1'b0;

  bit p_fp [8], p_exc [8];
  int p_dest [8], p_opnd [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit fp, input int dest, input int opnd,
                      input bit ex, output bit popped, output bit cleared);
    int c, h;
    bit ecom, eexc, ewb, epop, fbusy;
    @(posedge clk_i);
    #1;
    iq_valid_i = v; iq_is_fp_i = fp; iq_dest_i = DEST_W'(dest);
    iq_opnd_i = DATA_W'(opnd); iq_exc_i = ex;
    c = cyc;
    #2;
    h = mh;
    ecom  = (mc > 0) && (m_rdy[h] <= c);
    eexc  = ecom && m_exc[h];
    ewb   = ecom && !m_exc[h];
    fbusy = (c >= last_fp + 1) && (c <= last_fp + 2);
    epop  = v && !eexc && (mc < DEPTH) && !(fp && fbusy);
    if (v && mc == DEPTH) full_stalls++;
    chk(wb_valid_o == ewb, "R4 wb_valid timing", int'(wb_valid_o), int'(ewb));
    if (ewb && wb_valid_o) begin
      chk(int'(wb_data_o) == m_data[h], m_rdy[h] > 0 && m_data[h] >= 0 ? "R2/R3 wb data" : "R2 wb data",
          int'(wb_data_o), m_data[h]);
      chk(int'(wb_dest_o) == m_dest[h], "R4 wb dest", int'(wb_dest_o), m_dest[h]);
      chk(int'(wb_seq_o) == m_seq[h], "R10 wb seq", int'(wb_seq_o), m_seq[h]);
    end
    chk(exc_valid_o == eexc, "R8 exc_valid", int'(exc_valid_o), int'(eexc));
    chk(iq_clear_o == eexc, "R8 iq_clear", int'(iq_clear_o), int'(eexc));
    if (eexc && exc_valid_o)
      chk(int'(exc_seq_o) == m_seq[h], "R8 exc seq", int'(exc_seq_o), m_seq[h]);
    if (mc == DEPTH)
      chk(iq_pop_o == epop, "R7 full stall", int'(iq_pop_o), int'(epop));
    else if (v && fp && fbusy)
      chk(iq_pop_o == epop, "R6 fp busy", int'(iq_pop_o), int'(epop));
    else if (after_exc)
      chk(iq_pop_o == epop, "R9 accept after flush", int'(iq_pop_o), int'(epop));
    else
      chk(iq_pop_o == epop, "R1 accept", int'(iq_pop_o), int'(epop));
    if (wb_valid_o) wb_seen++;
    if (ecom) begin
      mh = (mh + 1) % 64;
      mc--;
    end
    if (eexc) begin
      mh = mt; mc = 0; last_fp = -100; after_exc = 1'b1;
    end
    if (epop) begin
      m_seq[mt]  = nseq;
      m_dest[mt] = dest % (1 << DEST_W);
      m_data[mt] = fp ? ((opnd * 3) & DMASK) : ((opnd + 1) & DMASK);
      m_rdy[mt]  = fp ? c + 4 : c + 2;
      m_exc[mt]  = ex;
      mt = (mt + 1) % 64;
      mc++;
      nseq = (nseq + 1) % SEQ_M;
      if (fp) last_fp = c;
      after_exc = 1'b0;
    end
    popped  = iq_pop_o;
    cleared = iq_clear_o;
  endtask

  task automatic run_prog(input int len);
    int idx = 0, guard = 0;
    bit ab = 1'b0, p, cl;
    while (!((idx >= len || ab) && mc == 0) && guard < 200) begin
      if (idx < len && !ab) begin
        step(1'b1, p_fp[idx], p_dest[idx], p_opnd[idx], p_exc[idx], p, cl);
        if (p) idx++;
      end else begin
        step(1'b0, 1'b0, 0, 0, 1'b0, p, cl);
      end
      if (cl) ab = 1'b1;
      guard++;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #3;
    chk(wb_valid_o == 1'b0, "R1 reset wb_valid", int'(wb_valid_o), 0);
    chk(exc_valid_o == 1'b0, "R1 reset exc_valid", int'(exc_valid_o), 0);
    chk(iq_clear_o == 1'b0, "R1 reset iq_clear", int'(iq_clear_o), 0);
    chk(iq_pop_o == 1'b0, "R1 reset pop", int'(iq_pop_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 R3 R4 R6 R10: every int/fp mix of five, no exception
    for (int pat = 0; pat < 32; pat++) begin
      for (int i = 0; i < 5; i++) begin
        p_fp[i]   = pat[i];
        p_exc[i]  = 1'b0;
        p_dest[i] = (pat + i * 3) % 32;
        p_opnd[i] = (pat * 997 + i * 4111 + 65530) & DMASK;
      end
      run_prog(5);
    end

    // R7: fp at head blocks five ints
    p_fp[0] = 1'b1;
    for (int i = 1; i < 6; i++) p_fp[i] = 1'b0;
    for (int i = 0; i < 6; i++) begin
      p_exc[i] = 1'b0; p_dest[i] = i + 20; p_opnd[i] = 1000 + i;
    end
    full_stalls = 0;
    run_prog(6);
    chk(full_stalls > 0, "R7 full reached", full_stalls, 1);

    // R8 R9: fault at each position of every mix
    for (int pat = 0; pat < 32; pat++) begin
      for (int pos = 0; pos < 5; pos++) begin
        int wb0;
        for (int i = 0; i < 5; i++) begin
          p_fp[i]   = pat[i];
          p_exc[i]  = (i == pos);
          p_dest[i] = (pat + pos + i) % 32;
          p_opnd[i] = (pat * 131 + pos * 17 + i * 7) & DMASK;
        end
        wb0 = wb_seen;
        run_prog(5);
        chk(wb_seen - wb0 == pos, "R8 older commits only", wb_seen - wb0, pos);
      end
    end

    repeat (4) begin
      bit p, cl;
      step(1'b0, 1'b0, 0, 0, 1'b0, p, cl);
    end
    finish_run();
  end
endmodule